// File: doc/BRIEF.md
# USB Endpoint Toggle and Duplicate Filter

This block keeps the configuration and data-toggle state of a bank of USB device endpoints. Each endpoint holds an enable bit, a direction bit and a two-bit transfer type. A byte-wide register port writes and reads that state for the endpoint that the select input names. The toggle status is visible on this port but software cannot write it.

A packet engine upstream reports each received packet. The report carries an endpoint number, a PID code and a completion strobe. For each packet, the block updates the endpoint's toggle state and decides whether the packet is new data to keep or a host retry to throw away. The rule depends on the endpoint type. Bulk and interrupt endpoints drop a packet that repeats the last accepted toggle. A SETUP packet re-synchronises a control endpoint. Isochronous endpoints keep every packet.

The decision leaves the block as a one-cycle accept or discard pulse. Packet decoding, CRC checking, FIFOs and handshake generation are done elsewhere.

Top module: `usb_ep_toggle_tracker`

## Requirements
- R1: A configuration byte holds enable in bit 7, toggle status in bit 3, direction in bit 2 and type in bits 1:0. Bits 6:4 always read 0, and a write to bits 6:4 or bit 3 has no effect.
- R2: After `rst` or `usb_rst`, endpoint 0 reads 0x80 (enabled, control) and every other endpoint reads 0x00.
- R3: The type codes are 00 control, 01 isochronous, 10 bulk and 11 interrupt. On a bulk endpoint, a data packet whose toggle matches the expected toggle is accepted and the expected toggle flips. Any other data packet is discarded and the expected toggle stays as it was.
- R4: An interrupt endpoint applies the same accept and discard rule as a bulk endpoint.
- R5: On a control endpoint, a SETUP packet is accepted, clears the toggle status and makes DATA1 the next expected toggle. Data packets on a control endpoint then follow the bulk rule.
- R6: An isochronous endpoint accepts every DATA0 and DATA1 packet and never discards one.
- R7: On an enabled endpoint, every processed DATA1 packet sets the toggle status and every processed DATA0 packet clears it, whether the packet is accepted or discarded.
- R8: A configuration write clears the endpoint's toggle status and sets its expected toggle back to DATA0.
- R9: A packet to a disabled endpoint is neither accepted nor discarded and leaves that endpoint's state unchanged.
- R10: The PID codes are 00 DATA0, 01 DATA1, 10 SETUP and 11 reserved. A SETUP packet to a non-control endpoint, and any packet with the reserved code, produces no pulse and changes no state.
- R11: The accept or discard pulse comes one cycle after `pkt_done` and lasts one cycle. The two pulses are never high together.
- R12: `reg_rdata` shows the byte of the endpoint named by `reg_sel` one cycle later. The direction bit is stored and read back but has no effect on decisions.
- R13: When a configuration write and a packet hit the same endpoint in the same cycle, the decision uses the state from before the write, and the write decides the state that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| usb_rst | input | 1 | Synchronous USB bus reset, same effect as rst |
| reg_sel | input | 3 | Endpoint selected for register read and write |
| reg_wr | input | 1 | Write strobe for the selected configuration byte |
| reg_wdata | input | 8 | Configuration byte to write |
| reg_rdata | output | 8 | Registered configuration byte of the selected endpoint |
| pkt_done | input | 1 | Completion strobe of a received packet |
| pkt_ep | input | 3 | Endpoint number of the packet |
| pkt_pid | input | 2 | PID code of the packet |
| pkt_accept | output | 1 | Pulse: packet is new data |
| pkt_discard | output | 1 | Pulse: packet is a retry to drop |

## Verification
The assertions assume `pkt_ep` and `reg_sel` always name one of the built endpoints. They also assume that the reset inputs are the only source of the first known state. The bench sets the endpoint count to a power of two, so every select value is valid. It holds `rst` high from time zero, so no property looks back into the cycles before reset.

Random stimulus draws all four PID codes and all four types, and it enables and disables endpoints at random. This covers the SETUP-on-wrong-type and reserved-code cases. Random writes also overlap packets to the same endpoint, which exercises the same-cycle rule.

// File: rtl/usb_ept_pkg.sv
package usb_ept_pkg;
  typedef enum logic [1:0] {
    EP_CTRL = 2'b00,
    EP_ISO  = 2'b01,
    EP_BULK = 2'b10,
    EP_INTR = 2'b11
  } ep_kind_e;

  typedef enum logic [1:0] {
    PID_D0    = 2'b00,
    PID_D1    = 2'b01,
    PID_SETUP = 2'b10,
    PID_RSV   = 2'b11
  } rx_pid_e;

  typedef struct packed {
    logic     en;
    logic     dir;
    ep_kind_e kind;
    logic     tgl;
    logic     exp;
  } ep_state_t;
endpackage

// File: rtl/ept_judge.sv
module ept_judge
  import usb_ept_pkg::*;
(
  input  ep_state_t st,
  input  logic [1:0] pid,
  output logic       accept,
  output logic       dup,
  output logic       upd,
  output logic       nxt_tgl,
  output logic       nxt_exp
);
  always_comb begin
    accept  = 1'b0;
    dup     = 1'b0;
    upd     = 1'b0;
    nxt_tgl = st.tgl;
    nxt_exp = st.exp;
    if (st.en) begin
      unique case (st.kind)
        EP_ISO: begin
          if (pid == PID_D0 || pid == PID_D1) begin
            accept  = 1'b1;
            upd     = 1'b1;
            nxt_tgl = pid[0];
          end
        end
        default: begin
          if (pid == PID_SETUP) begin
            if (st.kind == EP_CTRL) begin
              accept  = 1'b1;
              upd     = 1'b1;
              nxt_tgl = 1'b0;
              nxt_exp = 1'b1;
            end
          end else if (pid != PID_RSV) begin
            upd     = 1'b1;
            nxt_tgl = pid[0];
            if (pid[0] == st.exp) begin
              accept  = 1'b1;
              nxt_exp = ~st.exp;
            end else begin
              dup = 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R11
  always_comb begin
    judge_excl_chk: assert (!(accept && dup));
  end
endmodule

// File: rtl/ept_slot.sv
module ept_slot
  import usb_ept_pkg::*;
#(
  parameter bit IS_EP0 = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       usb_rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       upd,
  input  logic       nxt_tgl,
  input  logic       nxt_exp,
  output ep_state_t  st_q
);
  logic clr;
  assign clr = rst | usb_rst;

  always_ff @(posedge clk) begin
    if (clr) begin
      st_q.en   <= IS_EP0;
      st_q.dir  <= 1'b0;
      st_q.kind <= EP_CTRL;
      st_q.tgl  <= 1'b0;
      st_q.exp  <= 1'b0;
    end else if (wr) begin
      st_q.en   <= wdata[7];
      st_q.dir  <= wdata[2];
      st_q.kind <= ep_kind_e'(wdata[1:0]);
      st_q.tgl  <= 1'b0;
      st_q.exp  <= 1'b0;
    end else if (upd) begin
      st_q.tgl  <= nxt_tgl;
      st_q.exp  <= nxt_exp;
    end
  end

  // R2
  ep_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(usb_rst) |-> (st_q.en == IS_EP0) && (st_q.kind == EP_CTRL) && !st_q.tgl);
  // R8
  cfg_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wr && !usb_rst) |-> !st_q.tgl && !st_q.exp);
endmodule

// File: rtl/usb_ep_toggle_tracker.sv
module usb_ep_toggle_tracker
  import usb_ept_pkg::*;
#(
  parameter int NUM_EP = 8,
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           usb_rst,
  input  logic [EPW-1:0] reg_sel,
  input  logic           reg_wr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  input  logic           pkt_done,
  input  logic [EPW-1:0] pkt_ep,
  input  logic [1:0]     pkt_pid,
  output logic           pkt_accept,
  output logic           pkt_discard
);
  ep_state_t st [NUM_EP];
  ep_state_t st_pkt;
  ep_state_t st_rd;
  logic j_acc, j_dup, j_upd, j_tgl, j_exp;

  genvar g;
  generate
    for (g = 0; g < NUM_EP; g++) begin : g_slot
      ept_slot #(.IS_EP0(g == 0)) u_slot (
        .clk     (clk),
        .rst     (rst),
        .usb_rst (usb_rst),
        .wr      (reg_wr && (reg_sel == EPW'(g))),
        .wdata   (reg_wdata),
        .upd     (pkt_done && j_upd && (pkt_ep == EPW'(g))),
        .nxt_tgl (j_tgl),
        .nxt_exp (j_exp),
        .st_q    (st[g])
      );
    end
  endgenerate

  assign st_pkt = st[pkt_ep];
  assign st_rd  = st[reg_sel];

  ept_judge u_judge (
    .st      (st_pkt),
    .pid     (pkt_pid),
    .accept  (j_acc),
    .dup     (j_dup),
    .upd     (j_upd),
    .nxt_tgl (j_tgl),
    .nxt_exp (j_exp)
  );

  always_ff @(posedge clk) begin
    if (rst || usb_rst) begin
      pkt_accept  <= 1'b0;
      pkt_discard <= 1'b0;
      reg_rdata   <= 8'h00;
    end else begin
      pkt_accept  <= pkt_done && j_acc;
      pkt_discard <= pkt_done && j_dup;
      reg_rdata   <= {st_rd.en, 3'b000, st_rd.tgl, st_rd.dir, st_rd.kind};
    end
  end

  // R11
  out_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pkt_accept, pkt_discard}));
  // R11
  pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_accept || pkt_discard) |-> $past(pkt_done && !usb_rst));
  // R9
  disabled_chk: assert property (@(posedge clk) disable iff (rst || usb_rst)
    $past(pkt_done && !st_pkt.en) |-> !pkt_accept && !pkt_discard);
  // R6
  iso_chk: assert property (@(posedge clk) disable iff (rst || usb_rst)
    $past(pkt_done && st_pkt.kind == EP_ISO) |-> !pkt_discard);
  // R1
  rsv_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[6:4] == 3'b000);
endmodule

// File: tb/tb_usb_ep_toggle_tracker.sv
`timescale 1ns/1ps
module tb_usb_ep_toggle_tracker;
  localparam int NEP = 8;
  localparam int EW  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic usb_rst = 1'b0;
  logic [EW-1:0] reg_sel = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic pkt_done = 1'b0;
  logic [EW-1:0] pkt_ep = '0;
  logic [1:0] pkt_pid = '0;
  logic pkt_accept, pkt_discard;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic       m_en  [NEP];
  logic       m_dir [NEP];
  logic [1:0] m_typ [NEP];
  logic       m_tgl [NEP];
  logic       m_exp [NEP];

  always #2 clk = ~clk;

  usb_ep_toggle_tracker #(.NUM_EP(NEP)) dut (
    .clk(clk), .rst(rst), .usb_rst(usb_rst),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pkt_done(pkt_done), .pkt_ep(pkt_ep), .pkt_pid(pkt_pid),
    .pkt_accept(pkt_accept), .pkt_discard(pkt_discard)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void m_reset();
    for (int i = 0; i < NEP; i++) begin
      m_en[i] = (i == 0); m_dir[i] = 0; m_typ[i] = 2'b00; m_tgl[i] = 0; m_exp[i] = 0;
    end
  endfunction

  function automatic logic [7:0] m_byte(int e);
    return {m_en[e], 3'b000, m_tgl[e], m_dir[e], m_typ[e]};
  endfunction

  // decision by the rules of R3..R10; returns {accept, discard}
  function automatic logic [1:0] m_pkt(int e, logic [1:0] pid, bit apply);
    logic [1:0] r = 2'b00;
    if (!m_en[e] || pid == 2'b11) return r;                 // R9, R10
    if (pid == 2'b10) begin
      if (m_typ[e] == 2'b00) begin                            // R5
        r = 2'b10;
        if (apply) begin m_tgl[e] = 0; m_exp[e] = 1; end
      end
      return r;                                               // R10
    end
    if (m_typ[e] == 2'b01) begin                              // R6
      r = 2'b10;
      if (apply) m_tgl[e] = pid[0];
      return r;
    end
    r = (pid[0] == m_exp[e]) ? 2'b10 : 2'b01;                 // R3, R4
    if (apply) begin
      m_tgl[e] = pid[0];                                      // R7
      if (r == 2'b10) m_exp[e] = ~m_exp[e];
    end
    return r;
  endfunction

  function automatic void m_wr(int e, logic [7:0] d);
    m_en[e] = d[7]; m_dir[e] = d[2]; m_typ[e] = d[1:0]; m_tgl[e] = 0; m_exp[e] = 0;
  endfunction

  // one cycle with optional write and optional packet, then check decision pulse
  task automatic step(bit w, int we, logic [7:0] wd, bit p, int pe, logic [1:0] pid, string req);
    logic [1:0] ex = 2'b00;
    @(negedge clk);
    reg_wr = w; reg_sel = EW'(we); reg_wdata = wd;
    pkt_done = p; pkt_ep = EW'(pe); pkt_pid = pid;
    if (p) ex = m_pkt(pe, pid, !(w && we == pe));            // R13: write wins
    if (w) m_wr(we, wd);
    @(negedge clk);
    reg_wr = 0; pkt_done = 0;
    chk(req, {6'b0, pkt_accept, pkt_discard}, {6'b0, ex});
  endtask

  task automatic pkt(int e, logic [1:0] pid, string req);
    step(0, 0, 8'h00, 1, e, pid, req);
  endtask

  task automatic wr(int e, logic [7:0] d);
    step(1, e, d, 0, 0, 2'b00, "R1");
  endtask

  task automatic rd(int e, string req);
    @(negedge clk);
    reg_sel = EW'(e);
    @(negedge clk);
    chk(req, reg_rdata, m_byte(e));
  endtask

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R2 reset state
    for (int i = 0; i < NEP; i++) rd(i, "R2");
    chk("R11", {6'b0, pkt_accept, pkt_discard}, 8'h00);

    // R1 reserved and toggle bits ignored on write
    wr(3, 8'hFE);
    rd(3, "R1");
    chk("R1", reg_rdata, 8'h86);

    // R3 bulk
    wr(1, 8'h82);
    pkt(1, 2'b00, "R3"); pkt(1, 2'b00, "R3"); pkt(1, 2'b01, "R3");
    rd(1, "R7");
    pkt(1, 2'b01, "R3"); pkt(1, 2'b00, "R3");
    // R8 rewrite resets expected
    wr(1, 8'h86);
    rd(1, "R8");
    pkt(1, 2'b01, "R8"); pkt(1, 2'b00, "R12");
    // R4 interrupt
    wr(2, 8'h83);
    pkt(2, 2'b00, "R4"); pkt(2, 2'b00, "R4"); pkt(2, 2'b01, "R4");
    // R5 control
    pkt(0, 2'b10, "R5"); pkt(0, 2'b01, "R5"); pkt(0, 2'b01, "R5"); pkt(0, 2'b00, "R5");
    pkt(0, 2'b10, "R5"); rd(0, "R5"); pkt(0, 2'b01, "R5");
    // R6 iso
    wr(4, 8'h81);
    pkt(4, 2'b00, "R6"); pkt(4, 2'b00, "R6"); pkt(4, 2'b01, "R6");
    rd(4, "R7");
    // R10 setup on bulk, reserved pid
    pkt(1, 2'b10, "R10"); pkt(0, 2'b11, "R10"); rd(1, "R10");
    // R9 disabled
    wr(5, 8'h02);
    pkt(5, 2'b01, "R9"); rd(5, "R9");
    // R13 same-cycle write and packet
    step(1, 1, 8'h82, 1, 1, 2'b00, "R13"); rd(1, "R13");
    // R2 bus reset
    @(negedge clk); usb_rst = 1;
    @(negedge clk); usb_rst = 0; m_reset();
    for (int i = 0; i < NEP; i++) rd(i, "R2");

    // random mix
    void'($urandom(32'h5EED1));
    for (int n = 0; n < 4000; n++) begin
      int sel = $urandom_range(0, 9);
      if (sel == 0)
        step(1, $urandom_range(0, NEP-1), 8'($urandom), 0, 0, 2'b00, "R1");
      else if (sel == 1)
        step(1, $urandom_range(0, NEP-1), {1'b1, 7'($urandom)},
             1, $urandom_range(0, NEP-1), 2'($urandom), "R13");
      else if (sel == 2)
        rd($urandom_range(0, NEP-1), "R12");
      else
        pkt($urandom_range(0, NEP-1), 2'($urandom), "R11");
    end
    for (int i = 0; i < NEP; i++) rd(i, "R7");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule